// File: doc/BRIEF.md
# Once-per-second RMS and mean result engine

This block turns the one-second accumulated sums of an energy metering datapath into calibrated results. A controller pulses `start` together with a quantity code, the 48-bit accumulated sum for that quantity, and the calibration offset and gain words. The engine averages the sum over 4096 samples with an arithmetic shift right by 12. For the current and voltage RMS results it takes a bit-serial square root, one root bit per clock. For the mean active and mean reactive power results it skips the root. Every path then subtracts the offset and multiplies by the gain. When the result is ready, the engine raises `done` for one clock.

The engine keeps the most recent RMS current, RMS voltage, mean active power and apparent power results. Two further quantity codes use these stored results. The apparent power code multiplies the stored RMS current by the stored RMS voltage. The power factor code divides the stored mean active power by the stored apparent power, using a bit-serial divider. A zero apparent power skips the divider and gives a power factor of zero.

Results use one of two signed 24-bit fixed-point formats. The fraction format has 1 sign bit and 23 fraction bits and covers the range -1 to 1. The gain format has 2 integer bits (sign included) and 22 fraction bits and covers the range -2 to 2. Any value outside its format saturates to the end code of that format.

Top module: `rms_mean_unit`

## Requirements
- R1: Quantity codes 2 (mean active power) and 3 (mean reactive power) give sat(floor((sat(sat(acc_sum >>> 12) - offset) * gain) / 2^22)), with arithmetic shifts.
- R2: Quantity codes 0 (RMS current) and 1 (RMS voltage) clamp m = acc_sum >>> 12 to the range 0..2^23-1 and take r = floor(sqrt(m * 2^23)). They then apply the same offset and gain step as R1 to r.
- R3: The gain word is read in the 2.22 format, and the product is shifted right by 22 with floor rounding. A gain of 0x400000 therefore leaves its input unchanged.
- R4: Every intermediate result and every final result outside the range -2^23..2^23-1 saturates to 0x800000 or 0x7FFFFF.
- R5: Quantity code 4 gives sat(floor(Irms * Vrms / 2^23)), where Irms and Vrms are the last code 0 and code 1 results. The offset and gain inputs have no effect.
- R6: Quantity code 5 gives sat(trunc(P * 2^22 / S)) in the 2.22 format, truncated toward zero. P is the last code 2 result and S is the last code 4 result.
- R7: When the stored S is zero, code 5 gives 0 without running the divider.
- R8: Each accepted start gives exactly one `done` pulse, one clock long. `result` changes only in that clock and holds its value until the next pulse.
- R9: `start` is ignored while an operation is in progress. The running operation completes with its own inputs.
- R10: After reset, `result` is 0, `done` is 0, and the stored Irms, Vrms, P and S are all 0.
- R11: Quantity codes 6 and 7 give a result of 0, with a `done` pulse.
- R12: `done` rises no more than 64 clocks after the edge that accepts `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts an operation when the engine is idle |
| sel | input | 3 | Quantity code |
| acc_sum | input | 48 | Signed one-second accumulated sum |
| offset | input | 24 | Signed offset, 1.23 format |
| gain | input | 24 | Signed gain, 2.22 format |
| result | output | 24 | Signed result of the last operation |
| done | output | 1 | One-clock pulse when `result` is updated |

## Verification
A wrong root bit, a wrong quotient bit or an off-by-one iteration count changes `result` at the very next `done` pulse. The bench compares every result against an independent integer model. A corrupted stored RMS or power value is caught differently. It does not show at the operation that writes it. It shows only at a later apparent power or power factor operation, so the vector table orders these codes after their producers. A control fault, such as a lost `done`, a double pulse or a restart while busy, shows as a missing or extra pulse within the 64-clock window. It can also show as a result that belongs to the wrong inputs.

// File: rtl/rmu_pkg.sv
package rmu_pkg;

    parameter int WORD_W    = 24;
    parameter int ACC_W     = 48;
    parameter int AVG_SHIFT = 12;
    parameter int FRAC_A    = 23;
    parameter int FRAC_B    = 22;
    parameter int LAT_MAX   = 64;

    localparam logic [2:0] SEL_IRMS  = 3'd0;
    localparam logic [2:0] SEL_VRMS  = 3'd1;
    localparam logic [2:0] SEL_PMEAN = 3'd2;
    localparam logic [2:0] SEL_QMEAN = 3'd3;
    localparam logic [2:0] SEL_APPAR = 3'd4;
    localparam logic [2:0] SEL_PFAC  = 3'd5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_SQRT,
        ST_SCALE,
        ST_DIV,
        ST_FIN
    } rmu_state_t;

    function automatic logic signed [63:0] sx_word(input logic signed [WORD_W-1:0] v);
        return {{(64-WORD_W){v[WORD_W-1]}}, v};
    endfunction

    function automatic logic signed [63:0] sx_acc(input logic signed [ACC_W-1:0] v);
        return {{(64-ACC_W){v[ACC_W-1]}}, v};
    endfunction

    function automatic logic signed [WORD_W-1:0] sat_word(input logic signed [63:0] x);
        logic signed [63:0] hi;
        logic signed [63:0] lo;
        hi = (64'sd1 <<< (WORD_W-1)) - 64'sd1;
        lo = -(64'sd1 <<< (WORD_W-1));
        if (x > hi)      return hi[WORD_W-1:0];
        else if (x < lo) return lo[WORD_W-1:0];
        else             return x[WORD_W-1:0];
    endfunction

endpackage

// File: rtl/rmu_sqrt.sv
module rmu_sqrt #(
    parameter int ROOT_W = 23,
    localparam int RAD_W = 2*ROOT_W,
    localparam int CNT_W = $clog2(ROOT_W+1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [RAD_W-1:0]  radicand,
    output logic              fin,
    output logic [ROOT_W-1:0] root
);

    typedef struct packed {
        logic              run;
        logic              fin;
        logic [CNT_W-1:0]  cnt;
        logic [RAD_W-1:0]  rad;
        logic [RAD_W-1:0]  hold;
        logic [ROOT_W+2:0] rem;
        logic [ROOT_W-1:0] root;
    } sq_reg_t;

    sq_reg_t r_q, r_d;

    logic [ROOT_W+2:0] rem_sh;
    logic [ROOT_W+2:0] trial;

    always_comb begin
        r_d     = r_q;
        r_d.fin = 1'b0;
        rem_sh  = {r_q.rem[ROOT_W:0], r_q.rad[RAD_W-1:RAD_W-2]};
        trial   = {1'b0, r_q.root, 2'b01};
        if (go && !r_q.run) begin
            r_d.run  = 1'b1;
            r_d.cnt  = CNT_W'(ROOT_W);
            r_d.rad  = radicand;
            r_d.hold = radicand;
            r_d.rem  = '0;
            r_d.root = '0;
        end else if (r_q.run) begin
            r_d.rad = {r_q.rad[RAD_W-3:0], 2'b00};
            if (rem_sh >= trial) begin
                r_d.rem  = rem_sh - trial;
                r_d.root = {r_q.root[ROOT_W-2:0], 1'b1};
            end else begin
                r_d.rem  = rem_sh;
                r_d.root = {r_q.root[ROOT_W-2:0], 1'b0};
            end
            r_d.cnt = r_q.cnt - 1'b1;
            if (r_q.cnt == CNT_W'(1)) begin
                r_d.run = 1'b0;
                r_d.fin = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign fin  = r_q.fin;
    assign root = r_q.root;

    // R2
    root_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.fin |-> (({{(64-ROOT_W){1'b0}}, r_q.root} * {{(64-ROOT_W){1'b0}}, r_q.root})
                        <= {{(64-RAD_W){1'b0}}, r_q.hold})
                 && ((({{(64-ROOT_W){1'b0}}, r_q.root} + 64'd1) * ({{(64-ROOT_W){1'b0}}, r_q.root} + 64'd1))
                        > {{(64-RAD_W){1'b0}}, r_q.hold}));

endmodule

// File: rtl/rmu_div.sv
module rmu_div #(
    parameter int N_W = 46,
    parameter int D_W = 24,
    localparam int CNT_W = $clog2(N_W+1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go,
    input  logic [N_W-1:0] dividend,
    input  logic [D_W-1:0] divisor,
    output logic           fin,
    output logic [N_W-1:0] quotient
);

    typedef struct packed {
        logic             run;
        logic             fin;
        logic [CNT_W-1:0] cnt;
        logic [N_W-1:0]   dvd;
        logic [D_W-1:0]   dsr;
        logic [D_W-1:0]   rem;
        logic [N_W-1:0]   hold;
    } dv_reg_t;

    dv_reg_t r_q, r_d;

    logic [D_W:0] rem_sh;
    logic [D_W:0] rem_sub;

    always_comb begin
        r_d     = r_q;
        r_d.fin = 1'b0;
        rem_sh  = {r_q.rem, r_q.dvd[N_W-1]};
        rem_sub = rem_sh - {1'b0, r_q.dsr};
        if (go && !r_q.run) begin
            r_d.run  = 1'b1;
            r_d.cnt  = CNT_W'(N_W);
            r_d.dvd  = dividend;
            r_d.hold = dividend;
            r_d.dsr  = divisor;
            r_d.rem  = '0;
        end else if (r_q.run) begin
            if (rem_sh >= {1'b0, r_q.dsr}) begin
                r_d.rem = rem_sub[D_W-1:0];
                r_d.dvd = {r_q.dvd[N_W-2:0], 1'b1};
            end else begin
                r_d.rem = rem_sh[D_W-1:0];
                r_d.dvd = {r_q.dvd[N_W-2:0], 1'b0};
            end
            r_d.cnt = r_q.cnt - 1'b1;
            if (r_q.cnt == CNT_W'(1)) begin
                r_d.run = 1'b0;
                r_d.fin = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign fin      = r_q.fin;
    assign quotient = r_q.dvd;

    // R6
    quot_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.fin |-> ({{(64-N_W){1'b0}}, r_q.dvd} * {{(64-D_W){1'b0}}, r_q.dsr}
                     + {{(64-D_W){1'b0}}, r_q.rem}) == {{(64-N_W){1'b0}}, r_q.hold});

endmodule

// File: rtl/rmu_scale.sv
module rmu_scale
    import rmu_pkg::*;
(
    input  logic signed [WORD_W-1:0] val,
    input  logic signed [WORD_W-1:0] off,
    input  logic signed [WORD_W-1:0] gain,
    output logic signed [WORD_W-1:0] res
);

    logic signed [WORD_W-1:0] diff;
    logic signed [63:0]       prod;

    always_comb begin
        diff = sat_word(sx_word(val) - sx_word(off));
        prod = sx_word(diff) * sx_word(gain);
        res  = sat_word(prod >>> FRAC_B);
    end

endmodule

// File: rtl/rms_mean_unit.sv
module rms_mean_unit
    import rmu_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [2:0]               sel,
    input  logic signed [ACC_W-1:0]  acc_sum,
    input  logic signed [WORD_W-1:0] offset,
    input  logic signed [WORD_W-1:0] gain,
    output logic signed [WORD_W-1:0] result,
    output logic                     done
);

    localparam int ROOT_W = WORD_W - 1;
    localparam int RAD_W  = 2 * ROOT_W;
    localparam int DVD_W  = WORD_W + FRAC_B;
    localparam int DSR_W  = WORD_W;

    typedef struct packed {
        rmu_state_t               st;
        logic [2:0]               sel;
        logic signed [ACC_W-1:0]  acc;
        logic signed [WORD_W-1:0] off;
        logic signed [WORD_W-1:0] gain;
        logic signed [WORD_W-1:0] val;
        logic signed [WORD_W-1:0] res;
        logic signed [WORD_W-1:0] irms;
        logic signed [WORD_W-1:0] vrms;
        logic signed [WORD_W-1:0] pmean;
        logic signed [WORD_W-1:0] sapp;
        logic                     neg;
        logic signed [WORD_W-1:0] out;
        logic                     done;
    } top_reg_t;

    top_reg_t r_q, r_d;

    logic                     sqrt_go, sqrt_fin;
    logic [RAD_W-1:0]         rad_in;
    logic [ROOT_W-1:0]        root;
    logic                     div_go, div_fin;
    logic [DVD_W-1:0]         dvd_in;
    logic [DSR_W-1:0]         dsr_in;
    logic [DVD_W-1:0]         quot;
    logic signed [WORD_W-1:0] scaled;

    logic signed [ACC_W-1:0]  avg;
    logic [ROOT_W-1:0]        ms_clamp;
    logic [WORD_W-1:0]        pmag;
    logic [WORD_W-1:0]        smag;
    logic signed [63:0]       app_prod;
    logic signed [63:0]       qv;

    rmu_sqrt #(.ROOT_W(ROOT_W)) sqrt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (sqrt_go),
        .radicand (rad_in),
        .fin      (sqrt_fin),
        .root     (root)
    );

    rmu_div #(.N_W(DVD_W), .D_W(DSR_W)) div_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .dividend (dvd_in),
        .divisor  (dsr_in),
        .fin      (div_fin),
        .quotient (quot)
    );

    rmu_scale scale_i (
        .val  (r_q.val),
        .off  (r_q.off),
        .gain (r_q.gain),
        .res  (scaled)
    );

    // operand shaping feeding the iterative units
    always_comb begin
        avg = r_q.acc >>> AVG_SHIFT;
        if (avg[ACC_W-1])
            ms_clamp = '0;
        else if (avg > $signed({{(ACC_W-ROOT_W){1'b0}}, {ROOT_W{1'b1}}}))
            ms_clamp = '1;
        else
            ms_clamp = avg[ROOT_W-1:0];
        rad_in   = {ms_clamp, {ROOT_W{1'b0}}};
        pmag     = r_q.pmean[WORD_W-1] ? WORD_W'(-r_q.pmean) : WORD_W'(r_q.pmean);
        smag     = r_q.sapp[WORD_W-1]  ? WORD_W'(-r_q.sapp)  : WORD_W'(r_q.sapp);
        dvd_in   = {pmag, {FRAC_B{1'b0}}};
        dsr_in   = smag;
        app_prod = sx_word(r_q.irms) * sx_word(r_q.vrms);
        qv       = {{(64-DVD_W){1'b0}}, quot};
    end

    // next-state logic
    always_comb begin
        r_d     = r_q;
        r_d.done = 1'b0;
        sqrt_go = 1'b0;
        div_go  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.sel  = sel;
                    r_d.acc  = acc_sum;
                    r_d.off  = offset;
                    r_d.gain = gain;
                    r_d.st   = ST_PREP;
                end
            end
            ST_PREP: begin
                case (r_q.sel)
                    SEL_IRMS, SEL_VRMS: begin
                        sqrt_go  = 1'b1;
                        r_d.st   = ST_SQRT;
                    end
                    SEL_PMEAN, SEL_QMEAN: begin
                        r_d.val  = sat_word(sx_acc(avg));
                        r_d.st   = ST_SCALE;
                    end
                    SEL_APPAR: begin
                        r_d.res  = sat_word(app_prod >>> FRAC_A);
                        r_d.st   = ST_FIN;
                    end
                    SEL_PFAC: begin
                        if (r_q.sapp == '0) begin
                            r_d.res = '0;
                            r_d.st  = ST_FIN;
                        end else begin
                            div_go  = 1'b1;
                            r_d.neg = r_q.pmean[WORD_W-1] ^ r_q.sapp[WORD_W-1];
                            r_d.st  = ST_DIV;
                        end
                    end
                    default: begin
                        r_d.res = '0;
                        r_d.st  = ST_FIN;
                    end
                endcase
            end
            ST_SQRT: begin
                if (sqrt_fin) begin
                    r_d.val = $signed({1'b0, root});
                    r_d.st  = ST_SCALE;
                end
            end
            ST_SCALE: begin
                r_d.res = scaled;
                r_d.st  = ST_FIN;
            end
            ST_DIV: begin
                if (div_fin) begin
                    r_d.res = sat_word(r_q.neg ? -qv : qv);
                    r_d.st  = ST_FIN;
                end
            end
            ST_FIN: begin
                r_d.out  = r_q.res;
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
                case (r_q.sel)
                    SEL_IRMS:  r_d.irms  = r_q.res;
                    SEL_VRMS:  r_d.vrms  = r_q.res;
                    SEL_PMEAN: r_d.pmean = r_q.res;
                    SEL_APPAR: r_d.sapp  = r_q.res;
                    default: ;
                endcase
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign result = r_q.out;
    assign done   = r_q.done;

    // latency watch for the completion window
    logic [7:0] lat_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                lat_cnt <= '0;
        else if (r_q.st == ST_IDLE) lat_cnt <= '0;
        else if (lat_cnt != 8'hFF) lat_cnt <= lat_cnt + 8'd1;
    end

    // R12
    latency_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lat_cnt < 8'(LAT_MAX));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE) |=> ($stable(r_q.sel) && $stable(r_q.acc)));

    // R7
    pf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_PREP && r_q.sel == SEL_PFAC && r_q.sapp == '0)
            |=> (r_q.st == ST_FIN && r_q.res == '0));

endmodule

// File: tb/rms_mean_unit_tb_top.sv
module rms_mean_unit_tb_top;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NV = 12;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [2:0]         sel = '0;
    logic signed [47:0] acc_sum = '0;
    logic signed [23:0] offset = '0;
    logic signed [23:0] gain = '0;
    logic signed [23:0] result;
    logic               done;

    int n_checks = 0;
    int n_errors = 0;

    // model state
    longint m_irms = 0, m_vrms = 0, m_p = 0, m_s = 0;

    localparam logic [2:0] V_SEL [NV] = '{3'd0, 3'd1, 3'd2, 3'd4, 3'd5, 3'd3,
                                          3'd0, 3'd2, 3'd1, 3'd4, 3'd5, 3'd6};
    localparam logic [47:0] V_ACC [NV] = '{
        48'(64'h200000 << 12),
        48'(64'h100000 << 12),
        48'((64'h123456 << 12) + 64'h7FF),
        48'h0,
        48'h0,
        48'(-(64'sh300000 <<< 12)),
        48'hF000_0000_0000,
        48'h3FFF_FFFF_FFFF,
        48'h0100_0000_0000,
        48'h0,
        48'h0,
        48'h0000_1234_0000};
    localparam logic [23:0] V_OFF [NV] = '{24'h000000, 24'h001000, 24'h000010, 24'h7FFFFF,
                                           24'h000000, 24'hFFF000, 24'h000100, 24'h800000,
                                           24'h000000, 24'h123456, 24'h000000, 24'h000100};
    localparam logic [23:0] V_GAIN [NV] = '{24'h400000, 24'h480000, 24'h400000, 24'h000000,
                                            24'h400000, 24'h3C0000, 24'h400000, 24'h7FFFFF,
                                            24'h400000, 24'h7FFFFF, 24'h000000, 24'h400000};

    rms_mean_unit dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .sel     (sel),
        .acc_sum (acc_sum),
        .offset  (offset),
        .gain    (gain),
        .result  (result),
        .done    (done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic longint sat(longint x);
        if (x > 64'sd8388607)  return 64'sd8388607;
        if (x < -64'sd8388608) return -64'sd8388608;
        return x;
    endfunction

    function automatic longint isqrt(longint n);
        longint rt = 0;
        for (int b = 23; b >= 0; b--) begin
            longint t = rt | (64'sd1 << b);
            if (t * t <= n) rt = t;
        end
        return rt;
    endfunction

    function automatic longint scale(longint v, longint o, longint g);
        longint d = sat(v - o);
        return sat((d * g) >>> 22);
    endfunction

    function automatic longint ref_op(logic [2:0] s, logic [47:0] a, logic [23:0] o, logic [23:0] g);
        longint av  = longint'($signed(a)) >>> 12;
        longint ol  = longint'($signed(o));
        longint gl  = longint'($signed(g));
        longint res = 0;
        case (s)
            3'd0, 3'd1: begin
                longint m = av < 0 ? 0 : (av > 8388607 ? 8388607 : av);
                res = scale(isqrt(m << 23), ol, gl);
                if (s == 3'd0) m_irms = res; else m_vrms = res;
            end
            3'd2, 3'd3: begin
                res = scale(sat(av), ol, gl);
                if (s == 3'd2) m_p = res;
            end
            3'd4: begin
                res = sat((m_irms * m_vrms) >>> 23);
                m_s = res;
            end
            3'd5: begin
                if (m_s == 0) res = 0;
                else begin
                    longint mp = m_p < 0 ? -m_p : m_p;
                    longint ms = m_s < 0 ? -m_s : m_s;
                    longint q  = (mp << 22) / ms;
                    res = sat(((m_p < 0) != (m_s < 0)) ? -q : q);
                end
            end
            default: res = 0;
        endcase
        return res;
    endfunction

    function automatic string tag_of(logic [2:0] s);
        case (s)
            3'd0, 3'd1: return "R2,R3";
            3'd2, 3'd3: return "R1,R3,R4";
            3'd4:       return "R5,R4";
            3'd5:       return "R6,R4";
            default:    return "R11";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] s, input logic [47:0] a, input logic [23:0] o,
                          input logic [23:0] g, output logic [23:0] res, output int lat,
                          output int pulses);
        @(negedge clk);
        sel = s; acc_sum = a; offset = o; gain = g; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        res = result;
        pulses = done ? 1 : 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (done) pulses++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog R12: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [23:0] res;
        longint exp;
        int lat, pulses;

        repeat (3) @(negedge clk);
        // R10: reset values at the ports
        check(result == 24'h0, "R10", result, 0);
        check(done == 1'b0, "R10", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(result == 24'h0 && done == 1'b0, "R10", result, 0);

        // R7 and R10: stored S is zero after reset, power factor is zero and fast
        run_op(3'd5, 48'h0, 24'h0, 24'h400000, res, lat, pulses);
        exp = ref_op(3'd5, 48'h0, 24'h0, 24'h400000);
        check(res == 24'(exp) && exp == 0, "R7", res, exp);
        check(lat <= 4, "R7", lat, 4);
        // R10: stored Irms and Vrms are zero after reset
        run_op(3'd4, 48'h0, 24'h1, 24'h1, res, lat, pulses);
        check(res == 24'h0, "R10,R5", res, 0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            exp = ref_op(V_SEL[i], V_ACC[i], V_OFF[i], V_GAIN[i]);
            run_op(V_SEL[i], V_ACC[i], V_OFF[i], V_GAIN[i], res, lat, pulses);
            check(res == 24'(exp), tag_of(V_SEL[i]), res, exp);
            // R8: exactly one done pulse
            check(pulses == 1, "R8", pulses, 1);
            // R12: latency bound
            check(lat <= 64, "R12", lat, 64);
        end

        // R8: result holds after the pulse
        repeat (5) @(negedge clk);
        check(result == res, "R8", result, res);

        // R9: start pulses during a running operation are ignored
        exp = ref_op(3'd0, 48'(64'h200000 << 12), 24'h000200, 24'h400000);
        @(negedge clk);
        sel = 3'd0; acc_sum = 48'(64'h200000 << 12); offset = 24'h000200; gain = 24'h400000;
        start = 1'b1;
        @(negedge clk);
        sel = 3'd2; acc_sum = 48'(64'h010000 << 12); offset = 24'h0; gain = 24'h400000;
        lat = 1; pulses = 0;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        check(result == 24'(exp), "R9", result, exp);
        pulses = done ? 1 : 0;
        repeat (80) begin
            @(negedge clk);
            if (done) pulses++;
        end
        check(pulses == 1, "R9", pulses, 1);

        // R7: S forced to zero again, then power factor skips the divider
        exp = ref_op(3'd4, 48'h0, 24'h0, 24'h0);
        run_op(3'd1, 48'h0, 24'h0, 24'h400000, res, lat, pulses);
        exp = ref_op(3'd1, 48'h0, 24'h0, 24'h400000);
        check(res == 24'(exp), "R2", res, exp);
        exp = ref_op(3'd4, 48'h0, 24'h0, 24'h0);
        run_op(3'd4, 48'h0, 24'h0, 24'h0, res, lat, pulses);
        check(res == 24'(exp) && exp == 0, "R5", res, exp);
        exp = ref_op(3'd5, 48'h0, 24'h0, 24'h0);
        run_op(3'd5, 48'h0, 24'h0, 24'h0, res, lat, pulses);
        check(res == 24'h0, "R7", res, 0);

        // R11: code 7 gives zero
        run_op(3'd7, 48'h0000_4000_0000, 24'h0, 24'h400000, res, lat, pulses);
        check(res == 24'h0 && pulses == 1, "R11", res, 0);

        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule